// File: doc/BRIEF.md
# Per-Core Escalating Watchdog Timer

Each core of a multi-core chip gets its own independent watchdog. Software programs a configuration word for a core, holding a period length and an escalation mode, and then keeps the watchdog alive by strobing that core's poke input. If a whole period passes without a poke, the watchdog moves forward by one escalation stage. The first missed period raises a maskable interrupt. The second raises a non-maskable interrupt. The third issues a one-cycle request for a chip-wide soft reset.

One period lasts LEN × 2^(LOW_W+PRE_W) clocks. A PRE_W-bit prescaler produces one tick every 2^PRE_W clocks. The tick steps a (LEN_W+LOW_W)-bit down-counter whose upper LEN_W bits are loaded from LEN. With the defaults (16, 8, 8) one LEN unit is 65536 clocks, and the longest period, selected by LEN = 0, is 2^32 clocks. Each core exposes a readable status word. Its two low bits give the stage, so a non-maskable-interrupt handler can tell whether the watchdog caused the interrupt.

The configuration data bus is shared by all cores. A per-core write strobe picks the core that takes the word.

Top module: `wdog_array`

## Requirements
- R1: After reset every core is disabled: irq, nmi and soft-reset outputs are low and the status word is all zero.
- R2: With mode 1, 2 or 3, the first expiry follows exactly LEN × 2^(LOW_W+PRE_W) clocks after the restarting write. The restarting write is either a configuration write or a poke, and it takes effect at the clock edge where its strobe is sampled. At that expiry irq goes high and stays high.
- R3: In mode 2 or 3, a second expiry one period later raises nmi, and irq stays high.
- R4: In mode 3, a third expiry one period later drives the soft-reset request high for exactly one cycle. The stage then rests at 3 with no further request.
- R5: Mode 1 stops at the interrupt stage and never raises nmi. Mode 2 stops at the NMI stage and never requests a soft reset. Expiries past the last enabled stage have no effect.
- R6: A poke clears irq and nmi at the edge where it is sampled and returns the stage to 0. It also clears the prescaler and reloads the counter, so the next expiry comes a full period after the poke.
- R7: A configuration write restarts the core in the same way as a poke, using the new LEN and mode. Writing an all-zero word (mode 0) disables the core, and its outputs then stay low for as long as it is disabled.
- R8: The status word is {LEN, mode, stage}: bits [1:0] hold the stage (0 idle, 1 interrupt, 2 NMI, 3 reset requested), bits [3:2] hold the mode, and bits [LEN_W+3:4] hold LEN. Bit 1 is therefore set once the NMI stage is reached.
- R9: LEN = 0 selects the longest period, 2^(LEN_W+LOW_W+PRE_W) clocks.
- R10: Cores are independent: a write or poke to one core leaves the stage and timing of every other core unchanged.
- R11: The configuration word places mode in bits [1:0] and LEN in bits [LEN_W+1:2]. When a configuration write and a poke reach the same core in the same cycle, the write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | N_CORES | Per-core configuration write strobe |
| cfg_wdata_i | input | LEN_W+2 | Shared configuration word {LEN, mode} |
| poke_i | input | N_CORES | Per-core keep-alive strobe |
| irq_o | output | N_CORES | Interrupt stage reached (level) |
| nmi_o | output | N_CORES | NMI stage reached (level) |
| srst_req_o | output | N_CORES | One-cycle soft-reset request |
| status_o | output | N_CORES*(LEN_W+4) | Per-core {LEN, mode, stage}, core 0 in the low bits |

## Verification
The assertions assume three things about the inputs. A core's mode changes only through its own configuration write, so every change of stage is either a restart or a step caused by an expiry. Strobes are sampled one clock at a time. The shared data bus is valid whenever a strobe is high.

The bench drives each write and poke as a one-cycle pulse from the falling edge, with data set in the same half cycle, and never strobes two cores with different words in one cycle. It checks every transition of irq, nmi and the reset request against the exact clock edge predicted from LEN and the write time.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
   // escalation stage encoding (status bits [1:0])
   localparam logic [1:0] STG_IDLE = 2'd0;
   localparam logic [1:0] STG_IRQ  = 2'd1;
   localparam logic [1:0] STG_NMI  = 2'd2;
   localparam logic [1:0] STG_RST  = 2'd3;
   // mode encoding (configuration bits [1:0])
   localparam logic [1:0] MODE_OFF  = 2'd0;
   localparam logic [1:0] MODE_IRQ  = 2'd1;
   localparam logic [1:0] MODE_NMI  = 2'd2;
   localparam logic [1:0] MODE_FULL = 2'd3;
endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
   parameter int PRE_W = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   input  logic restart_i,
   output logic tick_o
);
   localparam logic [PRE_W-1:0] PRE_MAX = {PRE_W{1'b1}};

   logic [PRE_W-1:0] pre_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pre_q <= '0;
      else if (restart_i || !run_i)
         pre_q <= '0;
      else
         pre_q <= pre_q + 1'b1;
   end

   assign tick_o = run_i && !restart_i && (pre_q == PRE_MAX);

   // R2: ticks are separated by the full prescale interval
   p_tick_spaced_r2: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |=> !tick_o);
endmodule

// File: rtl/wdog_decrement.sv
module wdog_decrement #(
   parameter int LEN_W = 16,
   parameter int LOW_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             restart_i,
   input  logic             tick_i,
   input  logic [LEN_W-1:0] len_i,
   output logic             expire_o
);
   localparam int CNT_W = LEN_W + LOW_W;
   localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] reload;

   // LEN forms the upper bits; zero wraps to the longest count
   assign reload = {len_i, {LOW_W{1'b0}}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (restart_i || !run_i)
         cnt_q <= reload;
      else if (tick_i)
         cnt_q <= (cnt_q == CNT_ONE) ? reload : (cnt_q - CNT_ONE);
   end

   assign expire_o = run_i && !restart_i && tick_i && (cnt_q == CNT_ONE);

   // R6: a restart always leaves a freshly loaded counter behind
   p_restart_loads_r6: assert property (@(posedge clk) disable iff (!rst_n)
      restart_i |=> cnt_q == $past(reload));
endmodule

// File: rtl/wdog_escalate.sv
module wdog_escalate
   import wdog_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] mode_i,
   input  logic       restart_i,
   input  logic       expire_i,
   output logic [1:0] stage_o,
   output logic       irq_o,
   output logic       nmi_o,
   output logic       srst_o
);
   logic [1:0] stage_q;
   logic       srst_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q <= STG_IDLE;
         srst_q  <= 1'b0;
      end else begin
         srst_q <= 1'b0;
         if (restart_i || (mode_i == MODE_OFF)) begin
            stage_q <= STG_IDLE;
         end else if (expire_i) begin
            case (stage_q)
               STG_IDLE: stage_q <= STG_IRQ;
               STG_IRQ:  if (mode_i != MODE_IRQ) stage_q <= STG_NMI;
               STG_NMI:  if (mode_i == MODE_FULL) begin
                            stage_q <= STG_RST;
                            srst_q  <= 1'b1;
                         end
               default:  stage_q <= STG_RST;
            endcase
         end
      end
   end

   assign stage_o = stage_q;
   assign irq_o   = (stage_q != STG_IDLE);
   assign nmi_o   = stage_q[1];
   assign srst_o  = srst_q;

   // R4: the soft-reset request is a single-cycle pulse
   p_srst_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      srst_o |=> !srst_o);
   // R5: reset request only in full mode
   p_srst_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
      srst_o |-> mode_i == MODE_FULL);
   // R5: NMI stage only entered when the mode allows it
   p_nmi_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(nmi_o) |-> mode_i[1]);
   // R2: without a restart the stage only steps forward by one on an expiry
   p_stage_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (stage_q != $past(stage_q)) && !$past(restart_i) && (mode_i != MODE_OFF)
      |-> (stage_q == $past(stage_q) + 2'd1) && $past(expire_i));
endmodule

// File: rtl/wdog_core.sv
module wdog_core
   import wdog_pkg::*;
#(
   parameter int LEN_W = 16,
   parameter int LOW_W = 8,
   parameter int PRE_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we_i,
   input  logic [LEN_W-1:0] cfg_len_i,
   input  logic [1:0]       cfg_mode_i,
   input  logic             poke_i,
   output logic             irq_o,
   output logic             nmi_o,
   output logic             srst_o,
   output logic [LEN_W+3:0] status_o
);
   logic [LEN_W-1:0] len_q;
   logic [1:0]       mode_q;
   logic [LEN_W-1:0] len_next;
   logic             restart;
   logic             run;
   logic             tick;
   logic             expire;
   logic [1:0]       stage;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         len_q  <= '0;
         mode_q <= MODE_OFF;
      end else if (cfg_we_i) begin
         len_q  <= cfg_len_i;
         mode_q <= cfg_mode_i;
      end
   end

   assign restart  = cfg_we_i || poke_i;
   assign run      = (mode_q != MODE_OFF);
   assign len_next = cfg_we_i ? cfg_len_i : len_q;

   wdog_prescale #(.PRE_W(PRE_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .run_i(run), .restart_i(restart), .tick_o(tick));

   wdog_decrement #(.LEN_W(LEN_W), .LOW_W(LOW_W)) u_dec (
      .clk(clk), .rst_n(rst_n), .run_i(run), .restart_i(restart),
      .tick_i(tick), .len_i(len_next), .expire_o(expire));

   wdog_escalate u_esc (
      .clk(clk), .rst_n(rst_n), .mode_i(mode_q), .restart_i(restart),
      .expire_i(expire), .stage_o(stage), .irq_o(irq_o), .nmi_o(nmi_o),
      .srst_o(srst_o));

   assign status_o = {len_q, mode_q, stage};

   // R6: any poke or write returns the core to idle on the next cycle
   p_restart_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> !irq_o && !nmi_o && (status_o[1:0] == STG_IDLE));
   // R7: a disabled core is silent
   p_off_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_OFF) |-> !irq_o && !nmi_o && !srst_o);
   // R11: write wins over a simultaneous poke
   p_write_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we_i && poke_i |=> status_o[3:2] == $past(cfg_mode_i));
endmodule

// File: rtl/wdog_array.sv
module wdog_array #(
   parameter int N_CORES = 4,
   parameter int LEN_W   = 16,
   parameter int LOW_W   = 8,
   parameter int PRE_W   = 8,
   localparam int CFG_W  = LEN_W + 2,
   localparam int ST_W   = LEN_W + 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [N_CORES-1:0]      cfg_we_i,
   input  logic [CFG_W-1:0]        cfg_wdata_i,
   input  logic [N_CORES-1:0]      poke_i,
   output logic [N_CORES-1:0]      irq_o,
   output logic [N_CORES-1:0]      nmi_o,
   output logic [N_CORES-1:0]      srst_req_o,
   output logic [N_CORES*ST_W-1:0] status_o
);
   if (N_CORES < 1) begin : g_bad_cores
      $error("wdog_array: N_CORES must be at least 1");
   end
   if (LEN_W < 1) begin : g_bad_len
      $error("wdog_array: LEN_W must be at least 1");
   end
   if (LOW_W < 1) begin : g_bad_low
      $error("wdog_array: LOW_W must be at least 1");
   end
   if (PRE_W < 1) begin : g_bad_pre
      $error("wdog_array: PRE_W must be at least 1");
   end

   logic [1:0]       w_mode;
   logic [LEN_W-1:0] w_len;

   assign w_mode = cfg_wdata_i[1:0];
   assign w_len  = cfg_wdata_i[CFG_W-1:2];

   for (genvar i = 0; i < N_CORES; i++) begin : g_core
      wdog_core #(.LEN_W(LEN_W), .LOW_W(LOW_W), .PRE_W(PRE_W)) u_core (
         .clk(clk), .rst_n(rst_n),
         .cfg_we_i(cfg_we_i[i]), .cfg_len_i(w_len), .cfg_mode_i(w_mode),
         .poke_i(poke_i[i]),
         .irq_o(irq_o[i]), .nmi_o(nmi_o[i]), .srst_o(srst_req_o[i]),
         .status_o(status_o[i*ST_W +: ST_W]));
   end
endmodule

// File: tb/sim_wdog_array.sv
module sim_wdog_array;
   localparam int CLK_PERIOD = 10;
   localparam int NC    = 2;
   localparam int LEN_W = 8;
   localparam int LOW_W = 2;
   localparam int PRE_W = 2;
   localparam int ST_W  = LEN_W + 4;
   localparam int UNIT  = 1 << (LOW_W + PRE_W);   // clocks per LEN unit
   localparam int LIMIT = 150000;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic [NC-1:0]        cfg_we = '0;
   logic [LEN_W+1:0]     cfg_wdata = '0;
   logic [NC-1:0]        poke = '0;
   logic [NC-1:0]        irq, nmi, srst;
   logic [NC*ST_W-1:0]   status;

   int cyc = 0;
   int checks = 0;
   int errors = 0;

   typedef struct { int core; int kind; int at; int req; } ev_t;
   ev_t expq[$];

   wdog_array #(.N_CORES(NC), .LEN_W(LEN_W), .LOW_W(LOW_W), .PRE_W(PRE_W)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
      .poke_i(poke), .irq_o(irq), .nmi_o(nmi), .srst_req_o(srst),
      .status_o(status));

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      if (cyc > LIMIT) begin
         errors++;
         $display("FAIL watchdog: run hung, cycle %0d expected below %0d", cyc, LIMIT);
         summary();
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   function automatic int stat(input int c);
      return int'(status[c*ST_W +: ST_W]);
   endfunction

   // sorted insert of an expected output event
   task automatic expect_ev(input int core, input int kind, input int at, input int req);
      ev_t e;
      int idx;
      e.core = core; e.kind = kind; e.at = at; e.req = req;
      idx = expq.size();
      for (int i = 0; i < expq.size(); i++) begin
         if (expq[i].at > at) begin idx = i; break; end
      end
      expq.insert(idx, e);
   endtask

   // monitor: kind 1 irq rise, 2 nmi rise, 3 reset request
   logic [NC-1:0] irq_prev = '0, nmi_prev = '0;
   task automatic observe(input int core, input int kind);
      ev_t e;
      checks++;
      if (expq.size() == 0) begin
         errors++;
         $display("FAIL R7: unexpected event core %0d kind %0d at %0d, expected none",
                  core, kind, cyc);
      end else begin
         e = expq.pop_front();
         if (e.core != core || e.kind != kind || e.at != cyc) begin
            errors++;
            $display("FAIL R%0d: actual core %0d kind %0d at %0d, expected core %0d kind %0d at %0d",
                     e.req, core, kind, cyc, e.core, e.kind, e.at);
         end
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         for (int c = 0; c < NC; c++) begin
            if (irq[c] && !irq_prev[c]) observe(c, 1);
            if (nmi[c] && !nmi_prev[c]) observe(c, 2);
            if (srst[c]) observe(c, 3);
         end
      end
      irq_prev = irq;
      nmi_prev = nmi;
   end

   // drivers: return the clock edge that samples the strobe
   task automatic wr_cfg(input int core, input int len, input int mode, output int edge_n);
      @(negedge clk);
      cfg_wdata = {LEN_W'(len), 2'(mode)};
      cfg_we[core] = 1'b1;
      edge_n = cyc + 1;
      @(negedge clk);
      cfg_we = '0;
   endtask

   task automatic do_poke(input int core, output int edge_n);
      @(negedge clk);
      poke[core] = 1'b1;
      edge_n = cyc + 1;
      @(negedge clk);
      poke = '0;
   endtask

   task automatic wait_to(input int n);
      while (cyc < n) @(negedge clk);
   endtask

   initial begin
      int b, b1, p;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 irq", int'(irq), 0);
      chk("R1 nmi", int'(nmi), 0);
      chk("R1 status0", stat(0), 0);
      chk("R1 status1", stat(1), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // full escalation on core 0, LEN 3 (R2, R3, R4)
      wr_cfg(0, 3, 3, b);
      expect_ev(0, 1, b + 3*UNIT, 2);
      expect_ev(0, 2, b + 6*UNIT, 3);
      expect_ev(0, 3, b + 9*UNIT, 4);
      wait_to(b + 9*UNIT + 5);
      chk("R4 srst low after pulse", int'(srst[0]), 0);
      chk("R4 stage rests at 3", stat(0) & 3, 3);
      chk("R8 status fields", stat(0), (3 << 4) | (3 << 2) | 3);
      chk("R3 irq held", int'(irq[0]), 1);
      wait_to(b + 12*UNIT + 5);   // further expiry: no new pulse (monitor)

      // R6: poke clears, then R7 disable stays silent
      do_poke(0, p);
      chk("R6 irq cleared", int'(irq[0]), 0);
      chk("R6 nmi cleared", int'(nmi[0]), 0);
      chk("R6 stage idle", stat(0) & 3, 0);
      wr_cfg(0, 0, 0, b);
      chk("R7 disabled status", stat(0), 0);
      wait_to(b + 20*UNIT);
      chk("R7 silent irq", int'(irq[0]), 0);

      // R5: mode 1 stops at interrupt
      wr_cfg(1, 2, 1, b);
      expect_ev(1, 1, b + 2*UNIT, 2);
      wait_to(b + 8*UNIT);
      chk("R5 mode1 no nmi", int'(nmi[1]), 0);
      chk("R5 mode1 stage", stat(1) & 3, 1);

      // R5: mode 2 stops at NMI; R7 write restarts
      wr_cfg(1, 2, 2, b);
      chk("R7 write restarts irq", int'(irq[1]), 0);
      expect_ev(1, 1, b + 2*UNIT, 2);
      expect_ev(1, 2, b + 4*UNIT, 3);
      wait_to(b + 10*UNIT);
      chk("R5 mode2 stage", stat(1) & 3, 2);
      chk("R8 nmi bit1", (stat(1) >> 1) & 1, 1);

      // R6: poke mid-period restarts a full period
      wr_cfg(0, 2, 1, b);
      wait_to(b + 20);
      do_poke(0, p);
      expect_ev(0, 1, p + 2*UNIT, 6);
      wait_to(p + 2*UNIT + 3);
      chk("R6 irq after full period", int'(irq[0]), 1);

      // R9: LEN 0 gives the longest period
      wr_cfg(1, 0, 1, b);
      expect_ev(1, 1, b + (1 << (LEN_W + LOW_W + PRE_W)), 9);
      wait_to(b + (1 << (LEN_W + LOW_W + PRE_W)) + 3);
      chk("R9 irq after max period", int'(irq[1]), 1);

      // R10: independent cores
      wr_cfg(0, 4, 2, b);
      wr_cfg(1, 1, 2, b1);
      expect_ev(1, 1, b1 + UNIT, 10);
      expect_ev(1, 2, b1 + 2*UNIT, 10);
      expect_ev(0, 1, b + 4*UNIT, 10);
      expect_ev(0, 2, b + 8*UNIT, 10);
      wait_to(b1 + 2*UNIT + 3);
      do_poke(1, p);
      chk("R10 poked core idle", stat(1) & 3, 0);
      chk("R10 other core untouched", stat(0) & 3, 0);
      expect_ev(1, 1, p + UNIT, 10);
      expect_ev(1, 2, p + 2*UNIT, 10);
      wait_to(b + 8*UNIT + 3);
      chk("R10 core0 stage", stat(0) & 3, 2);
      chk("R10 core1 stage", stat(1) & 3, 2);

      // R11: write and poke together, write wins
      @(negedge clk);
      cfg_wdata = {LEN_W'(5), 2'(1)};
      cfg_we[0] = 1'b1;
      poke[0] = 1'b1;
      b = cyc + 1;
      @(negedge clk);
      cfg_we = '0;
      poke = '0;
      chk("R11 write wins", stat(0), (5 << 4) | (1 << 2));
      expect_ev(0, 1, b + 5*UNIT, 11);
      wait_to(b + 5*UNIT + 5);

      chk("R2 all expected events seen", expq.size(), 0);
      while (expq.size() > 0) begin
         ev_t e;
         e = expq.pop_front();
         errors++;
         $display("FAIL R%0d: missing event core %0d kind %0d, expected at %0d",
                  e.req, e.core, e.kind, e.at);
      end
      summary();
   end
endmodule